// File: doc/BRIEF.md
# Clause 22 Management Frame Master

This block drives the two-wire station management bus to an Ethernet PHY. Software places a complete 32-bit management frame in one register word. That word holds the start code, the operation, the PHY address, the register address, the turnaround code and 16 bits of data. The block first sends 32 preamble ones and then shifts the frame out, most significant bit first, on a management clock derived from the system clock. When the operation is a read, the block releases the data line during turnaround. It then samples the 16 data bits returned by the PHY and writes them into the low half of the same frame word.

A separate speed register sets the management clock. The clock's half period is the speed value in system clock cycles, so the clock runs at the system clock divided by twice the speed value. For a 2.5 MHz target, pick the speed value to suit the system clock. A speed value of zero keeps the clock stopped and blocks any transfer. Each finished transfer raises a one-cycle completion event.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, busy, mgmt_done, mdc and mdio_oe are low, and frame_rdata and the speed register are zero.
- R2: A frame_wr pulse while idle, with a nonzero speed value, stores the word and starts a transfer: busy is high from the next cycle.
- R3: The line carries 64 bits: 32 ones, then frame bits 31 down to 0. The frame fields are start code in 31:30 (01), operation in 29:28, PHY address in 27:23, register address in 22:18, turnaround code in 17:16 (10) and data in 15:0.
- R4: With speed value S, mdc is low at the start and toggles every S cycles while busy, so its first rising edge comes S cycles after the start edge. mdc stays low while idle.
- R5: mdio_o changes during a transfer only in the cycle in which mdc falls.
- R6: When the operation field is 10 (read), mdio_oe drops after bit 45 of the 64-bit sequence and stays low through the turnaround and data bits. For any other operation code, mdio_oe stays high for all 64 bits.
- R7: For a read, mdio_i is sampled on each mdc rising edge of the 16 data bits, most significant bit first. The result replaces frame bits 15:0 at completion, and bits 31:16 are kept. For other operations the frame word is unchanged.
- R8: mgmt_done pulses for exactly one cycle, in the cycle busy drops. That cycle comes 128·S cycles after the start edge.
- R9: With speed value zero, frame_wr stores the word but starts no transfer, and no mgmt_done follows.
- R10: frame_wr and speed_wr while busy are ignored. Neither the frame word nor the transfer timing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_wr | input | 1 | Write strobe for the frame word |
| frame_wdata | input | 32 | Frame word to write |
| speed_wr | input | 1 | Write strobe for the speed value |
| speed_wdata | input | SPD_W | Half period of mdc in system cycles |
| frame_rdata | output | 32 | Current frame word, with read data after a read |
| busy | output | 1 | Transfer in progress |
| mgmt_done | output | 1 | One-cycle completion event |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line input from the pad |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |

## Verification
The start takes effect at the clock edge after the write strobe. The mdc edges fall on multiples of S cycles after that start edge. The bit index advances every 2·S cycles, and completion with the read-data update lands exactly 128·S cycles after the start. A behavioural model in the bench counts cycles from the start edge and derives the expected mdc level, bit index, enable, line value, busy, done and frame word from that count. It compares them with the outputs at every falling system clock edge, away from the edge that updates them. The simulated PHY drives mdio_i at falling system edges from the model's bit index, so each value is stable long before the mdc rising edge that samples it. Transfer lengths are also measured end to end for speed values 1, 2 and 3.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int DATA_BITS  = 16;
  localparam int OP_MSB     = 29;
  localparam int OP_LSB     = 28;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int SPD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SPD_W-1:0] half_period,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [SPD_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap = run && (cnt_q == half_period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;

  // R4: the clock parks low whenever no transfer runs
  a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc_q);
  // R4: the half-period counter never passes the programmed value
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < half_period));
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int PRE = PRE_BITS,
  parameter int FW  = FRAME_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_wr,
  input  logic [FW-1:0] frame_wdata,
  input  logic          can_start,
  input  logic          rise_tick,
  input  logic          fall_tick,
  input  logic          mdio_i,
  output logic          busy,
  output logic          done,
  output logic [FW-1:0] frame,
  output logic          mdio_o,
  output logic          mdio_oe
);
  localparam int TOTAL    = PRE + FW;
  localparam int IDX_W    = $clog2(TOTAL);
  localparam int REL_IDX  = PRE + 14;
  localparam int DATA_IDX = PRE + 16;
  localparam int DW       = DATA_BITS;

  logic [TOTAL-1:0] sh_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    cap_q;
  logic [FW-1:0]    frame_q;
  logic             rd_q, busy_q, done_q, oe_q;
  logic             start, last;

  assign start = frame_wr && !busy_q && can_start;
  assign last  = (idx_q == IDX_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      idx_q   <= '0;
      cap_q   <= '0;
      frame_q <= '0;
      rd_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (frame_wr) frame_q <= frame_wdata;
        if (start) begin
          busy_q <= 1'b1;
          sh_q   <= {{PRE{1'b1}}, frame_wdata};
          idx_q  <= '0;
          rd_q   <= (frame_wdata[OP_MSB:OP_LSB] == OP_READ);
          oe_q   <= 1'b1;
          cap_q  <= '0;
        end
      end else begin
        if (rise_tick && rd_q && (idx_q >= IDX_W'(DATA_IDX)))
          cap_q <= {cap_q[DW-2:0], mdio_i};
        if (fall_tick) begin
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            oe_q   <= 1'b0;
            sh_q   <= '0;
            if (rd_q) frame_q[DW-1:0] <= cap_q;
          end else begin
            idx_q <= idx_q + 1'b1;
            sh_q  <= {sh_q[TOTAL-2:0], 1'b0};
            if (rd_q && (idx_q == IDX_W'(REL_IDX - 1))) oe_q <= 1'b0;
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign frame   = frame_q;
  assign mdio_o  = sh_q[TOTAL-1];
  assign mdio_oe = oe_q;

  // R8: completion is a single-cycle event
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R8: the event coincides with the end of a transfer
  a_r8_done_at_end: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));
  // R6: nothing is driven while idle
  a_r6_idle_release: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !oe_q);
  // R6: a read leaves the line released from turnaround onward
  a_r6_read_release: assert property (@(posedge clk) disable iff (rst)
    (busy_q && rd_q && (idx_q >= IDX_W'(REL_IDX))) |-> !oe_q);
  // R6: other operations drive for the whole frame
  a_r6_write_drive: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !rd_q) |-> oe_q);
  // R5: the output bit moves only on a falling mdc tick
  a_r5_shift_on_fall: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !fall_tick) |=> $stable(sh_q));
  // R10: the frame's header half holds through a transfer
  a_r10_frame_hold: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(frame_q[FW-1:DW]));
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int SPD_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_wr,
  input  logic [FRAME_BITS-1:0] frame_wdata,
  input  logic                  speed_wr,
  input  logic [SPD_W-1:0]      speed_wdata,
  output logic [FRAME_BITS-1:0] frame_rdata,
  output logic                  busy,
  output logic                  mgmt_done,
  output logic                  mdc,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe
);
  logic [SPD_W-1:0] speed_q;
  logic             busy_w, rise_w, fall_w;

  always_ff @(posedge clk) begin
    if (rst) speed_q <= '0;
    else if (speed_wr && !busy_w) speed_q <= speed_wdata;
  end

  mdio_clkdiv #(.SPD_W(SPD_W)) div_i (
    .clk        (clk),
    .rst        (rst),
    .run        (busy_w),
    .half_period(speed_q),
    .mdc        (mdc),
    .rise_tick  (rise_w),
    .fall_tick  (fall_w)
  );

  mdio_engine #(.PRE(PRE_BITS), .FW(FRAME_BITS)) eng_i (
    .clk        (clk),
    .rst        (rst),
    .frame_wr   (frame_wr),
    .frame_wdata(frame_wdata),
    .can_start  (speed_q != '0),
    .rise_tick  (rise_w),
    .fall_tick  (fall_w),
    .mdio_i     (mdio_i),
    .busy       (busy_w),
    .done       (mgmt_done),
    .frame      (frame_rdata),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );

  assign busy = busy_w;

  // R9: a transfer begins only with a nonzero speed value
  a_r9_start_needs_speed: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_w) |-> ($past(speed_q) != '0));
  // R10: the speed value is frozen during a transfer
  a_r10_speed_frozen: assert property (@(posedge clk) disable iff (rst)
    busy_w |=> $stable(speed_q));
endmodule

// File: tb/mdio_frame_master_tb.sv
module mdio_frame_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SPD_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_wr = 1'b0;
  logic [31:0] frame_wdata = '0;
  logic speed_wr = 1'b0;
  logic [SPD_W-1:0] speed_wdata = '0;
  logic [31:0] frame_rdata;
  logic busy, mgmt_done, mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_frame_master #(.SPD_W(SPD_W)) dut_i (
    .clk(clk), .rst(rst), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
    .speed_wr(speed_wr), .speed_wdata(speed_wdata), .frame_rdata(frame_rdata),
    .busy(busy), .mgmt_done(mgmt_done), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // behavioural reference model
  bit          m_busy, m_done, m_rd;
  int          m_cyc, m_speed, m_xs;
  logic [31:0] m_frame;
  logic [63:0] m_word;
  logic [15:0] m_cap;
  logic [15:0] phy_word = '0;

  always @(posedge clk) begin
    bit was_busy;
    was_busy = m_busy;
    if (rst) begin
      m_busy = 0; m_done = 0; m_rd = 0; m_cyc = 0; m_speed = 0; m_xs = 1;
      m_frame = '0; m_word = '0; m_cap = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cyc++;
        if ((m_cyc % (2*m_xs)) == m_xs && m_rd && (m_cyc / (2*m_xs)) >= 48)
          m_cap = {m_cap[14:0], mdio_i};
        if (m_cyc == 128*m_xs) begin
          m_busy = 0; m_done = 1;
          if (m_rd) m_frame[15:0] = m_cap;
        end
      end else if (frame_wr) begin
        m_frame = frame_wdata;
        if (m_speed != 0) begin
          m_busy = 1; m_cyc = 0; m_xs = m_speed; m_cap = '0;
          m_rd = (frame_wdata[29:28] == 2'b10);
          m_word = {32'hFFFF_FFFF, frame_wdata};
        end
      end
      if (speed_wr && !was_busy) m_speed = int'(speed_wdata);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison and simulated PHY
  logic p_mdc = 0, p_oe = 0, p_o = 0;
  int   done_seen = 0;
  always @(negedge clk) begin
    if (!rst && !finished) begin
      int idx;
      bit e_mdc, e_oe;
      idx   = m_cyc / (2*m_xs);
      e_mdc = m_busy ? (((m_cyc / m_xs) % 2) == 1) : 1'b0;
      e_oe  = m_busy && (!m_rd || idx < 46);
      chk(busy == m_busy, "R2 busy", 32'(busy), 32'(m_busy));
      chk(mdc == e_mdc, "R4 mdc", 32'(mdc), 32'(e_mdc));
      chk(mdio_oe == e_oe, "R6 mdio_oe", 32'(mdio_oe), 32'(e_oe));
      if (e_oe) chk(mdio_o == m_word[63-idx], "R3 mdio_o", 32'(mdio_o), 32'(m_word[63-idx]));
      chk(mgmt_done == m_done, "R8 mgmt_done", 32'(mgmt_done), 32'(m_done));
      chk(frame_rdata == m_frame, "R7 frame_rdata", frame_rdata, m_frame);
      if (mdio_oe && p_oe && (mdio_o != p_o))
        chk(p_mdc && !mdc, "R5 change off falling mdc", 32'(mdc), 32'(0));
      if (mgmt_done) done_seen++;
      p_mdc = mdc; p_oe = mdio_oe; p_o = mdio_o;
      if (m_busy && m_rd && idx >= 47)
        mdio_i = (idx == 47) ? 1'b0 : phy_word[63-idx];
      else
        mdio_i = 1'b1;
    end
  end

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                     input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  task automatic put_frame(input logic [31:0] w);
    frame_wr = 1; frame_wdata = w;
    @(negedge clk);
    frame_wr = 0;
  endtask

  task automatic put_speed(input int s);
    speed_wr = 1; speed_wdata = SPD_W'(s);
    @(negedge clk);
    speed_wr = 0;
  endtask

  // start a transfer and measure negedges until completion
  task automatic run_xfer(input logic [31:0] w, input int s, input int early_poke);
    int n;
    n = 0;
    frame_wr = 1; frame_wdata = w;
    @(negedge clk);
    frame_wr = 0;
    n = 1;
    while (!mgmt_done && n < 5000) begin
      if (early_poke != 0 && n == early_poke) begin
        frame_wr = 1; frame_wdata = 32'hDEAD_BEEF;
        speed_wr = 1; speed_wdata = 8'd7;
      end else begin
        frame_wr = 0; speed_wr = 0;
      end
      @(negedge clk);
      n++;
    end
    frame_wr = 0; speed_wr = 0;
    chk(n == 128*s + 1, "R8 transfer length", 32'(n), 32'(128*s + 1));
  endtask

  initial begin
    logic [31:0] f;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !mdc && !mdio_oe && !mgmt_done, "R1 idle outputs",
        {28'd0, busy, mdc, mdio_oe, mgmt_done}, 32'd0);
    chk(frame_rdata == 32'd0, "R1 frame zero", frame_rdata, 32'd0);

    // R9 speed zero blocks start
    f = mk(2'b01, 5'h03, 5'h04, 16'h1234);
    put_frame(f);
    repeat (40) @(negedge clk);
    chk(!busy && done_seen == 0, "R9 no transfer at speed zero", 32'(busy), 32'd0);
    chk(frame_rdata == f, "R9 word stored", frame_rdata, f);

    // R2/R3 write at speed 1
    put_speed(1);
    f = mk(2'b01, 5'h11, 5'h0A, 16'hA5C3);
    run_xfer(f, 1, 0);
    chk(frame_rdata == f, "R7 write keeps word", frame_rdata, f);

    // R6/R7 read at speed 2
    put_speed(2);
    phy_word = 16'hC35A;
    f = mk(2'b10, 5'h1F, 5'h01, 16'h0000);
    run_xfer(f, 2, 0);
    chk(frame_rdata == {f[31:16], 16'hC35A}, "R7 read data captured",
        frame_rdata, {f[31:16], 16'hC35A});

    // R10 writes during a read at speed 3 are ignored
    put_speed(3);
    phy_word = 16'h0F71;
    f = mk(2'b10, 5'h05, 5'h12, 16'hFFFF);
    run_xfer(f, 3, 50);
    chk(frame_rdata == {f[31:16], 16'h0F71}, "R10 word untouched by busy write",
        frame_rdata, {f[31:16], 16'h0F71});

    // R6 other op code drives the whole frame; speed still 3 (R10)
    f = {2'b01, 2'b00, 5'h0C, 5'h1D, 2'b10, 16'h5AA5};
    run_xfer(f, 3, 0);
    chk(frame_rdata == f, "R6 non-read op keeps word", frame_rdata, f);

    // back-to-back read right after completion (R2)
    phy_word = 16'h8001;
    f = mk(2'b10, 5'h00, 5'h1F, 16'h0000);
    run_xfer(f, 3, 0);
    chk(frame_rdata[15:0] == 16'h8001, "R7 back-to-back read", 32'(frame_rdata[15:0]), 32'h8001);

    repeat (5) @(negedge clk);
    chk(!mdc && !busy, "R4 idle mdc low", {30'd0, mdc, busy}, 32'd0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule